// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is a cycle-based model of the write-command front end of a byte-wide parallel NOR flash. Each clock cycle with the write strobe high is one bus write cycle carrying an address and a data byte. The decoder follows the multi-cycle unlock sequences and starts an embedded program operation when a sequence completes. The operation holds the ready output low for a fixed number of cycles and then merges the new byte into a small cell array. Reads are combinational from the address bus. During a program they return a status byte; otherwise they return the array contents.

Two banks sit behind the same address: the main array and a secured region. The secured region is selected while secured mode is active. A fast-program (unlock-bypass) mode drops the two unlock writes from every program. The bypass mode is refused while secured mode is active.

The sequencer has nine states. Every state goes back to IDLE_READ on reset.
- IDLE_READ: a write of AAh at 555h moves to GOT_UNLOCK1.
- GOT_UNLOCK1: a write of 55h at 2AAh moves to GOT_UNLOCK2. Any other write goes back to IDLE_READ.
- GOT_UNLOCK2: the command write at 555h picks the next step.
  - A0h moves to PROG_WAIT_DATA.
  - 20h moves to BYPASS_IDLE, but only when not secured.
  - 88h sets secured mode and returns to IDLE_READ, but only when not secured.
  - 90h moves to SEC_EXIT_WAIT, but only when secured.
  - Anything else goes back to IDLE_READ.
- SEC_EXIT_WAIT: a 00h write clears secured mode. The state returns to IDLE_READ in every case.
- PROG_WAIT_DATA: the next write gives the target and data and moves to PROG_BUSY.
- BYPASS_IDLE: A0h moves to BYPASS_WAIT_DATA and 90h moves to BYPASS_EXIT_WAIT. Other writes are ignored.
- BYPASS_WAIT_DATA: the next write moves to PROG_BUSY.
- BYPASS_EXIT_WAIT: 00h moves to IDLE_READ. Anything else goes back to BYPASS_IDLE.
- PROG_BUSY: writes are ignored. When the cycle count runs out, the state commits the byte and returns to IDLE_READ or BYPASS_IDLE.

Top module: `nor_cmd_decoder`

## Requirements
- R1: The four writes AAh@555h, 55h@2AAh, A0h@555h, D@A form a standard program. ready is low from the cycle after the fourth write for exactly PROG_CYC cycles. A then reads back old AND D.
- R2: The writes AAh@555h, 55h@2AAh, 20h@555h set in_bypass in the cycle after the third write.
- R3: In bypass mode, A0h at any address followed by D@A programs A. This can be repeated with no unlock writes, and in_bypass stays high afterwards.
- R4: In bypass mode, 90h then 00h at any addresses clears in_bypass. Any other write in bypass mode changes neither the array nor the mode.
- R5: Writes made while ready is low are ignored. They neither start nor advance a command sequence and change no cell.
- R6: A cell can only have bits cleared. While busy, a read returns bit 7 = NOT D[7] and bit 5 = 1 when D sets a bit that is 0 in the cell. All other status bits read 0.
- R7: An active-low reset aborts a running program at once. ready goes high, the cell keeps its old value, and both mode flags clear.
- R8: The writes AAh@555h, 55h@2AAh, 88h@555h set in_secure. Reads and programs then use a separate bank. The writes AAh@555h, 55h@2AAh, 90h@555h, 00h clear in_secure. The bypass entry sequence is refused while in_secure is set.
- R9: A write that does not match the expected step of a sequence returns the decoder to array read. Memory is not changed.
- R10: After a program completes, reads follow the current address bus and return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_we | input | 1 | Write strobe; one bus write per high cycle |
| bus_addr | input | ADDR_W | Address for writes and reads |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Array data, or the status byte while busy |
| ready | output | 1 | High when no embedded program is running |
| in_bypass | output | 1 | Unlock-bypass mode active |
| in_secure | output | 1 | Secured region selected |

## Verification
A write lands on the rising edge where bus_we is sampled high. Mode flags therefore change one cycle after the last write of a sequence, and ready falls in that same cycle. ready rises again PROG_CYC cycles later, together with the committed cell value. Reads are combinational, so read checks are made a little after an edge, once the address settles. The bench drives every write on a falling edge and samples on the following falling edge. The ready check looks at the PROG_CYC-1 and PROG_CYC boundaries so that a busy window one cycle too short or too long is caught.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    typedef enum logic [3:0] {
        IDLE_READ,
        GOT_UNLOCK1,
        GOT_UNLOCK2,
        PROG_WAIT_DATA,
        PROG_BUSY,
        BYPASS_IDLE,
        BYPASS_WAIT_DATA,
        BYPASS_EXIT_WAIT,
        SEC_EXIT_WAIT
    } seq_state_t;

    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  OP_PROGRAM = 8'hA0;
    localparam logic [7:0]  OP_BYPASS  = 8'h20;
    localparam logic [7:0]  OP_SEC_IN  = 8'h88;
    localparam logic [7:0]  OP_LEAVE1  = 8'h90;
    localparam logic [7:0]  OP_LEAVE2  = 8'h00;
endpackage

// File: rtl/nor_prog_timer.sv
module nor_prog_timer #(
    parameter int PROG_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(PROG_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R1: the busy window shrinks by one each cycle
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   rd_idx,
    output logic [7:0]       rd_data,
    input  logic             wr_en,
    input  logic [IDX_W:0]   wr_idx,
    input  logic [7:0]       wr_data
);
    localparam int CELLS = 2 ** (IDX_W + 1);

    logic [7:0] cell_q [CELLS];

    initial begin
        for (int i = 0; i < CELLS; i++) cell_q[i] = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (wr_en) cell_q[wr_idx] <= cell_q[wr_idx] & wr_data;
    end

    assign rd_data = cell_q[rd_idx];

    // R6: a commit never raises a bit of the target cell
    p_only_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cell_q[$past(wr_idx)] & ~$past(cell_q[wr_idx])) == 8'h00));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        cell_old,
    input  logic              prog_done,
    output logic              timer_start,
    output logic              commit,
    output logic [IDX_W:0]    commit_idx,
    output logic [7:0]        commit_data,
    output logic              busy,
    output logic              in_bypass,
    output logic              in_secure,
    output logic [7:0]        status
);
    seq_state_t       state_q, state_d;
    logic             sec_q, sec_d;
    logic             ret_byp_q;
    logic [IDX_W:0]   pend_idx_q;
    logic [7:0]       pend_data_q;
    logic             err_q;
    logic             hit_a, hit_b, at_key;

    assign at_key = (addr == ADDR_W'(KEY_ADDR_A));
    assign hit_a  = at_key && (wdata == KEY_DATA_A);
    assign hit_b  = (addr == ADDR_W'(KEY_ADDR_B)) && (wdata == KEY_DATA_B);

    always_comb begin
        state_d     = state_q;
        sec_d       = sec_q;
        timer_start = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            IDLE_READ:        if (we && hit_a) state_d = GOT_UNLOCK1;
            GOT_UNLOCK1:      if (we) state_d = hit_b ? GOT_UNLOCK2 : IDLE_READ;
            GOT_UNLOCK2: if (we) begin
                state_d = IDLE_READ;
                if (at_key && wdata == OP_PROGRAM)                state_d = PROG_WAIT_DATA;
                else if (at_key && wdata == OP_BYPASS && !sec_q)  state_d = BYPASS_IDLE;
                else if (at_key && wdata == OP_SEC_IN && !sec_q)  sec_d   = 1'b1;
                else if (at_key && wdata == OP_LEAVE1 && sec_q)   state_d = SEC_EXIT_WAIT;
            end
            SEC_EXIT_WAIT: if (we) begin
                state_d = IDLE_READ;
                if (wdata == OP_LEAVE2) sec_d = 1'b0;
            end
            PROG_WAIT_DATA, BYPASS_WAIT_DATA: if (we) begin
                state_d     = PROG_BUSY;
                timer_start = 1'b1;
            end
            PROG_BUSY: if (prog_done) begin
                commit  = 1'b1;
                state_d = ret_byp_q ? BYPASS_IDLE : IDLE_READ;
            end
            BYPASS_IDLE: if (we) begin
                if (wdata == OP_PROGRAM)     state_d = BYPASS_WAIT_DATA;
                else if (wdata == OP_LEAVE1) state_d = BYPASS_EXIT_WAIT;
            end
            BYPASS_EXIT_WAIT: if (we) state_d = (wdata == OP_LEAVE2) ? IDLE_READ : BYPASS_IDLE;
            default: state_d = IDLE_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= IDLE_READ;
            sec_q       <= 1'b0;
            ret_byp_q   <= 1'b0;
            pend_idx_q  <= '0;
            pend_data_q <= 8'hFF;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            sec_q   <= sec_d;
            if (timer_start) begin
                ret_byp_q   <= (state_q == BYPASS_WAIT_DATA);
                pend_idx_q  <= {sec_q, addr[IDX_W-1:0]};
                pend_data_q <= wdata;
                err_q       <= |(wdata & ~cell_old);
            end
        end
    end

    always_comb begin
        busy        = (state_q == PROG_BUSY);
        in_secure   = sec_q;
        in_bypass   = (state_q == BYPASS_IDLE) || (state_q == BYPASS_WAIT_DATA) ||
                      (state_q == BYPASS_EXIT_WAIT) || (busy && ret_byp_q);
        commit_idx  = pend_idx_q;
        commit_data = pend_data_q;
        status      = {~pend_data_q[7], 1'b0, err_q, 5'b0};
    end

    // R1: the data write of a standard program starts the busy phase
    p_prog_enters_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PROG_WAIT_DATA && we) |=> busy);
    // R5: a running program keeps its target whatever is written
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_done) |=> (busy && $stable(pend_data_q) && $stable(pend_idx_q)));
    // R8: bypass and secured modes exclude each other
    p_no_bypass_secure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_secure |-> !in_bypass);
    // R10: after the commit the decoder reads the array again
    p_commit_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
    parameter int ADDR_W   = 12,
    parameter int IDX_W    = 4,
    parameter int PROG_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              ready,
    output logic              in_bypass,
    output logic              in_secure
);
    logic           timer_start, prog_done, commit, busy;
    logic [IDX_W:0] commit_idx, rd_idx;
    logic [7:0]     commit_data, cell_rd, status;

    nor_cmd_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .cell_old(cell_rd), .prog_done(prog_done), .timer_start(timer_start),
        .commit(commit), .commit_idx(commit_idx), .commit_data(commit_data),
        .busy(busy), .in_bypass(in_bypass), .in_secure(in_secure), .status(status)
    );

    nor_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(timer_start), .done(prog_done)
    );

    assign rd_idx = {in_secure, bus_addr[IDX_W-1:0]};

    nor_cell_array #(.IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(cell_rd),
        .wr_en(commit), .wr_idx(commit_idx), .wr_data(commit_data)
    );

    assign ready     = !busy;
    assign bus_rdata = busy ? status : cell_rd;

    // R7: reset leaves the part ready
    p_reset_ready_r7: assert property (@(posedge clk) $rose(rst_n) |-> ready);
endmodule

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int PROG = 8;
    localparam int N = 58;

    logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0, rdata;
    logic ready, byp, sec;
    int total = 0, bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(12), .IDX_W(4), .PROG_CYC(PROG)) i_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .ready(ready), .in_bypass(byp), .in_secure(sec)
    );

    // entry: {req[3:0], op[1:0], addr[11:0], data[7:0]}
    // op 0 write, 1 read-check, 2 program wait, 3 flags {secure,bypass}
    localparam logic [25:0] TBL [N] = '{
        {4'd1, 2'd0, 12'h555, 8'hAA}, {4'd1, 2'd0, 12'h2AA, 8'h55},   // R1 standard program
        {4'd1, 2'd0, 12'h555, 8'hA0}, {4'd1, 2'd0, 12'h003, 8'h5A},
        {4'd1, 2'd2, 12'h000, 8'h00}, {4'd1, 2'd1, 12'h003, 8'h5A},
        {4'd6, 2'd0, 12'h555, 8'hAA}, {4'd6, 2'd0, 12'h2AA, 8'h55},   // R6 AND merge
        {4'd6, 2'd0, 12'h555, 8'hA0}, {4'd6, 2'd0, 12'h003, 8'hF0},
        {4'd6, 2'd2, 12'h000, 8'h00}, {4'd6, 2'd1, 12'h003, 8'h50},
        {4'd2, 2'd0, 12'h555, 8'hAA}, {4'd2, 2'd0, 12'h2AA, 8'h55},   // R2 bypass entry
        {4'd2, 2'd0, 12'h555, 8'h20}, {4'd2, 2'd3, 12'h000, 8'h01},
        {4'd3, 2'd0, 12'h7FF, 8'hA0}, {4'd3, 2'd0, 12'h004, 8'h33},   // R3 bypass program
        {4'd3, 2'd2, 12'h000, 8'h00}, {4'd3, 2'd1, 12'h004, 8'h33},
        {4'd3, 2'd0, 12'h123, 8'hA0}, {4'd3, 2'd0, 12'h005, 8'h0F},
        {4'd3, 2'd2, 12'h000, 8'h00}, {4'd3, 2'd1, 12'h005, 8'h0F},
        {4'd4, 2'd0, 12'h006, 8'h00}, {4'd4, 2'd3, 12'h000, 8'h01},   // R4 stray write
        {4'd4, 2'd1, 12'h006, 8'hFF}, {4'd4, 2'd0, 12'h000, 8'h90},
        {4'd4, 2'd0, 12'h456, 8'h00}, {4'd4, 2'd3, 12'h000, 8'h00},
        {4'd10, 2'd1, 12'h004, 8'h33},                                // R10 array read
        {4'd9, 2'd0, 12'h555, 8'hAA}, {4'd9, 2'd0, 12'h2AA, 8'h55},   // R9 broken sequence
        {4'd9, 2'd0, 12'h555, 8'h77}, {4'd9, 2'd0, 12'h007, 8'h00},
        {4'd9, 2'd1, 12'h007, 8'hFF}, {4'd9, 2'd3, 12'h000, 8'h00},
        {4'd8, 2'd0, 12'h555, 8'hAA}, {4'd8, 2'd0, 12'h2AA, 8'h55},   // R8 secured region
        {4'd8, 2'd0, 12'h555, 8'h88}, {4'd8, 2'd3, 12'h000, 8'h02},
        {4'd8, 2'd1, 12'h003, 8'hFF}, {4'd8, 2'd0, 12'h555, 8'hAA},
        {4'd8, 2'd0, 12'h2AA, 8'h55}, {4'd8, 2'd0, 12'h555, 8'hA0},
        {4'd8, 2'd0, 12'h003, 8'hC3}, {4'd8, 2'd2, 12'h000, 8'h00},
        {4'd8, 2'd1, 12'h003, 8'hC3}, {4'd8, 2'd0, 12'h555, 8'hAA},
        {4'd8, 2'd0, 12'h2AA, 8'h55}, {4'd8, 2'd0, 12'h555, 8'h20},
        {4'd8, 2'd3, 12'h000, 8'h02}, {4'd8, 2'd0, 12'h555, 8'hAA},
        {4'd8, 2'd0, 12'h2AA, 8'h55}, {4'd8, 2'd0, 12'h555, 8'h90},
        {4'd8, 2'd0, 12'h000, 8'h00}, {4'd8, 2'd3, 12'h000, 8'h00},
        {4'd8, 2'd1, 12'h003, 8'h50}
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input int req, input logic [11:0] a, input logic [7:0] exp);
        addr = a; #1; check(req, rdata, exp);
    endtask

    task automatic prog_wait(input int req);
        check(req, {7'b0, ready}, 8'h00);
        repeat (PROG - 1) @(negedge clk);
        check(req, {7'b0, ready}, 8'h00);
        @(negedge clk);
        check(req, {7'b0, ready}, 8'h01);
    endtask

    task automatic std_prog(input logic [11:0] a, input logic [7:0] d);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
    endtask

    initial begin
        repeat (PROG * 20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check(7, {5'b0, sec, byp, ready}, 8'h01);
        rd(10, 12'h000, 8'hFF);

        for (int i = 0; i < N; i++) begin
            unique case (TBL[i][21:20])
                2'd0: wr(TBL[i][19:8], TBL[i][7:0]);
                2'd1: rd(int'(TBL[i][25:22]), TBL[i][19:8], TBL[i][7:0]);
                2'd2: prog_wait(int'(TBL[i][25:22]));
                default: check(int'(TBL[i][25:22]), {6'b0, sec, byp}, TBL[i][7:0]);
            endcase
        end

        // R6 status: raising bit 7 of a cleared cell flags bit 5, bit 7 reads 0
        std_prog(12'h008, 8'h00); prog_wait(6);
        std_prog(12'h008, 8'h80);
        rd(6, 12'h008, 8'h20);
        prog_wait(6);
        rd(6, 12'h008, 8'h00);
        // R6 status without error: bit 7 reads NOT 0
        std_prog(12'h00A, 8'h7F);
        rd(6, 12'h00A, 8'h80);
        // R5 writes while busy are ignored
        wr(12'h009, 8'h00);
        wr(12'h555, 8'hAA);
        repeat (PROG) @(negedge clk);
        check(5, {7'b0, ready}, 8'h01);
        wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h009, 8'h00);
        check(5, {7'b0, ready}, 8'h01);
        rd(5, 12'h009, 8'hFF);
        rd(5, 12'h00A, 8'h7F);

        // R7 reset aborts a running program
        std_prog(12'h00B, 8'h00);
        @(negedge clk);
        rst_n = 1'b0; #1;
        check(7, {7'b0, ready}, 8'h01);
        @(negedge clk); rst_n = 1'b1;
        rd(7, 12'h00B, 8'hFF);
        rd(7, 12'h003, 8'h50);
        // R7 reset clears bypass mode
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h20);
        check(7, {6'b0, sec, byp}, 8'h01);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #1;
        check(7, {6'b0, sec, byp}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule